// File: doc/BRIEF.md
# Sticky Error Status Register Bank

This block gathers ten hardware error events (four fan-speed comparisons, four temperature-window comparisons and two regulator overheat inputs) and records each one in a bit of a small status register bank. Each record is sticky. A bit that has been set stays set after its event goes away, until software clears it by writing a one to that bit. A clear write is refused while the event's condition is still present. A summary flag goes high whenever any recorded bit is set.

Before an event can set its bit, it is filtered by the system sleep state. Some events are always blocked in certain sleep states. Others are blocked only when a programmable per-event mask bit is set. Zones three and four are never blocked.

Each status bit is a two-state machine. In state `ST_CLEAR` the bit reads 0. In state `ST_LATCHED` the bit reads 1. The transition **capture** (`ST_CLEAR` to `ST_LATCHED`) happens on any clock edge where the condition is present and not blocked. The transition **release** (`ST_LATCHED` to `ST_CLEAR`) happens only on an edge with a one written to that bit and the raw condition absent. Every other combination stays in the current state: **hold-clear** or **hold-latched**.

Top module: `err_status_bank`

## Requirements
- R1: After reset, both status registers read 00h and `host_err` is 0.
- R2: Fan register (`reg_addr`=0), bit i (i=0..3): sets when fan value i is greater than fan limit i, compared as unsigned. Equality does not set the bit. Bits 7:4 read 0.
- R3: Host register (`reg_addr`=1), bit i (i=0..3): sets when zone temperature i is below its low limit or above its high limit, all compared as signed 8-bit. Values exactly on a limit do not set the bit.
- R4: Host register bit 4+j sets while regulator-hot input j (j=0,1) is high. Bits 7:6 read 0.
- R5: A set bit stays set after its condition disappears.
- R6: A write of 1 to a status bit clears it, provided its raw condition is absent. A write of 0 leaves the bit unchanged.
- R7: A clear write to a bit whose raw condition (before masking) is present leaves the bit set.
- R8: An unmasked event on the same edge as a clear write to its bit leaves the bit set.
- R9: Sleep encoding is S0=0, S1=1, S3=2, S4/5=3. Fan events are always blocked in S4/5. In S1 and S3 a fan event is blocked when its `mask_fan` bit is 1. In S0 no fan event is blocked.
- R10: Zone 1 and zone 2 events (bits 0,1) are blocked in S3 and S4/5 when their `mask_zone` bit is 1. Zone 3 and zone 4 events are never blocked.
- R11: Regulator-hot events are always blocked in S3 and S4/5, and never in S0 or S1.
- R12: A blocked event cannot set its bit. Bits already set keep their value when blocking becomes active.
- R13: `host_err` is high exactly when any bit of either status register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fan_val | input | 32 | Four 8-bit fan tach readings, fan i at [8i+7:8i] |
| fan_lim | input | 32 | Four 8-bit fan tach limits |
| zone_temp | input | 32 | Four signed 8-bit zone temperatures |
| zone_lo | input | 32 | Four signed 8-bit low limits |
| zone_hi | input | 32 | Four signed 8-bit high limits |
| vr_hot | input | 2 | Regulator overheat inputs, active high |
| sleep_state | input | 2 | Sleep state code (R9) |
| mask_fan | input | 4 | Optional-mask enables for the fan events |
| mask_zone | input | 2 | Optional-mask enables for zones 1 and 2 |
| reg_wr | input | 1 | Write strobe (write-one-to-clear) |
| reg_addr | input | 1 | 0 selects the fan register, 1 selects the host register |
| reg_wdata | input | 8 | Write data, ones clear bits |
| reg_rdata | output | 8 | Read data of the selected register |
| host_err | output | 1 | Summary error flag |

## Verification
Two sweeps cover the comparators. The first walks a fan reading through all 256 values against a fixed limit, which separates strict greater-than from greater-or-equal and from signed comparison. The second walks a zone temperature through all signed values against a window that straddles zero, which exposes an off-by-one at either edge and an unsigned compare. A sweep over every sleep code and every combination of the six mask bits, with all events active, separates the fixed blocks from the optional ones and checks that each event follows its own mask bit rather than a neighbour's. Directed sequences exercise the capture, hold, release, refused-release and set-over-clear transitions, and confirm that blocking never erases bits that are already set.

// File: rtl/err_pkg.sv
package err_pkg;

    typedef enum logic {
        ST_CLEAR   = 1'b0,
        ST_LATCHED = 1'b1
    } bit_state_e;

    typedef logic [1:0] sleep_t;

    localparam sleep_t SLP_S0  = 2'd0;
    localparam sleep_t SLP_S1  = 2'd1;
    localparam sleep_t SLP_S3  = 2'd2;
    localparam sleep_t SLP_S45 = 2'd3;

    localparam logic ADDR_FAN  = 1'b0;
    localparam logic ADDR_HOST = 1'b1;

endpackage

// File: rtl/err_detect.sv
module err_detect #(
    parameter int NUM_FAN  = 4,
    parameter int NUM_ZONE = 4,
    parameter int NUM_VR   = 2,
    parameter int TW       = 8,
    localparam int NUM_EV  = NUM_FAN + NUM_ZONE + NUM_VR
) (
    input  logic [NUM_FAN*TW-1:0]  fan_val,
    input  logic [NUM_FAN*TW-1:0]  fan_lim,
    input  logic [NUM_ZONE*TW-1:0] zone_temp,
    input  logic [NUM_ZONE*TW-1:0] zone_lo,
    input  logic [NUM_ZONE*TW-1:0] zone_hi,
    input  logic [NUM_VR-1:0]      vr_hot,
    output logic [NUM_EV-1:0]      ev_raw
);

    // Fan events: unsigned strict greater-than against the limit.
    for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
        assign ev_raw[f] = fan_val[f*TW +: TW] > fan_lim[f*TW +: TW];
    end

    // Zone events: signed window compare.
    for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
        logic signed [TW-1:0] t_s, lo_s, hi_s;
        assign t_s  = zone_temp[z*TW +: TW];
        assign lo_s = zone_lo[z*TW +: TW];
        assign hi_s = zone_hi[z*TW +: TW];
        assign ev_raw[NUM_FAN + z] = (t_s < lo_s) || (t_s > hi_s);
    end

    // Regulator overheat events pass straight through.
    for (genvar v = 0; v < NUM_VR; v++) begin : g_vr
        assign ev_raw[NUM_FAN + NUM_ZONE + v] = vr_hot[v];
    end

endmodule

// File: rtl/err_mask.sv
module err_mask
    import err_pkg::*;
#(
    parameter int NUM_FAN      = 4,
    parameter int NUM_ZONE     = 4,
    parameter int NUM_OPT_ZONE = 2,
    parameter int NUM_VR       = 2,
    localparam int NUM_EV      = NUM_FAN + NUM_ZONE + NUM_VR
) (
    input  sleep_t                  sleep_state,
    input  logic [NUM_FAN-1:0]      mask_fan,
    input  logic [NUM_OPT_ZONE-1:0] mask_zone,
    output logic [NUM_EV-1:0]       ev_blk
);

    logic in_s1_or_s3;
    logic in_deep;

    assign in_s1_or_s3 = (sleep_state == SLP_S1) || (sleep_state == SLP_S3);
    assign in_deep     = (sleep_state == SLP_S3) || (sleep_state == SLP_S45);

    for (genvar f = 0; f < NUM_FAN; f++) begin : g_fan
        assign ev_blk[f] = (sleep_state == SLP_S45) || (in_s1_or_s3 && mask_fan[f]);
    end

    for (genvar z = 0; z < NUM_ZONE; z++) begin : g_zone
        if (z < NUM_OPT_ZONE) begin : g_opt
            assign ev_blk[NUM_FAN + z] = in_deep && mask_zone[z];
        end else begin : g_never
            assign ev_blk[NUM_FAN + z] = 1'b0;
        end
    end

    for (genvar v = 0; v < NUM_VR; v++) begin : g_vr
        assign ev_blk[NUM_FAN + NUM_ZONE + v] = in_deep;
    end

endmodule

// File: rtl/err_sticky_bit.sv
module err_sticky_bit
    import err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic blocked,
    input  logic clr,
    output logic latched
);

    bit_state_e state_q, state_d;
    logic       capture;

    assign capture = cond && !blocked;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (capture) state_d = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (clr && !cond) state_d = ST_CLEAR;
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        latched = (state_q == ST_LATCHED);
    end

    // R5
    hold_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && !clr) |=> (state_q == ST_LATCHED));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && clr && !cond) |=> (state_q == ST_CLEAR));

    // R7
    refuse_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCHED && clr && cond) |=> latched);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !blocked && clr) |=> latched);

    // R12
    blocked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR && (blocked || !cond)) |=> !latched);

endmodule

// File: rtl/err_status_bank.sv
module err_status_bank
    import err_pkg::*;
#(
    parameter int NUM_FAN      = 4,
    parameter int NUM_ZONE     = 4,
    parameter int NUM_OPT_ZONE = 2,
    parameter int NUM_VR       = 2,
    parameter int TW           = 8,
    parameter int REG_W        = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_FAN*TW-1:0]   fan_val,
    input  logic [NUM_FAN*TW-1:0]   fan_lim,
    input  logic [NUM_ZONE*TW-1:0]  zone_temp,
    input  logic [NUM_ZONE*TW-1:0]  zone_lo,
    input  logic [NUM_ZONE*TW-1:0]  zone_hi,
    input  logic [NUM_VR-1:0]       vr_hot,
    input  logic [1:0]              sleep_state,
    input  logic [NUM_FAN-1:0]      mask_fan,
    input  logic [NUM_OPT_ZONE-1:0] mask_zone,
    input  logic                    reg_wr,
    input  logic                    reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    host_err
);

    localparam int NUM_EV   = NUM_FAN + NUM_ZONE + NUM_VR;
    localparam int NUM_HOST = NUM_ZONE + NUM_VR;

    logic [NUM_EV-1:0] ev_raw;
    logic [NUM_EV-1:0] ev_blk;
    logic [NUM_EV-1:0] ev_clr;
    logic [NUM_EV-1:0] status;
    logic [REG_W-1:0]  fan_reg;
    logic [REG_W-1:0]  host_reg;

    err_detect #(
        .NUM_FAN (NUM_FAN),
        .NUM_ZONE(NUM_ZONE),
        .NUM_VR  (NUM_VR),
        .TW      (TW)
    ) u_detect (
        .fan_val  (fan_val),
        .fan_lim  (fan_lim),
        .zone_temp(zone_temp),
        .zone_lo  (zone_lo),
        .zone_hi  (zone_hi),
        .vr_hot   (vr_hot),
        .ev_raw   (ev_raw)
    );

    err_mask #(
        .NUM_FAN     (NUM_FAN),
        .NUM_ZONE    (NUM_ZONE),
        .NUM_OPT_ZONE(NUM_OPT_ZONE),
        .NUM_VR      (NUM_VR)
    ) u_mask (
        .sleep_state(sleep_state),
        .mask_fan   (mask_fan),
        .mask_zone  (mask_zone),
        .ev_blk     (ev_blk)
    );

    // Write-one-to-clear decode per event bit.
    for (genvar e = 0; e < NUM_EV; e++) begin : g_bit
        if (e < NUM_FAN) begin : g_fan_clr
            assign ev_clr[e] = reg_wr && (reg_addr == ADDR_FAN) && reg_wdata[e];
        end else begin : g_host_clr
            assign ev_clr[e] = reg_wr && (reg_addr == ADDR_HOST) && reg_wdata[e - NUM_FAN];
        end

        err_sticky_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond   (ev_raw[e]),
            .blocked(ev_blk[e]),
            .clr    (ev_clr[e]),
            .latched(status[e])
        );
    end

    // Register images with reserved bits at zero.
    always_comb begin
        fan_reg  = '0;
        host_reg = '0;
        fan_reg[NUM_FAN-1:0]   = status[NUM_FAN-1:0];
        host_reg[NUM_HOST-1:0] = status[NUM_EV-1:NUM_FAN];
    end

    assign reg_rdata = (reg_addr == ADDR_FAN) ? fan_reg : host_reg;
    assign host_err  = |status;

    // R13
    summary_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_err) |-> $past(|(ev_raw & ~ev_blk)));

    // R13
    summary_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_err) |-> $past(reg_wr));

endmodule

// File: tb/err_status_bank_bench.sv
module err_status_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fan_val, fan_lim, zone_temp, zone_lo, zone_hi;
    logic [1:0]  vr_hot, sleep_state, mask_zone;
    logic [3:0]  mask_fan;
    logic        reg_wr, reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        host_err;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    logic [9:0] exp_st = '0;

    always #10 clk = ~clk;

    err_status_bank u_err_status_bank (
        .clk(clk), .rst_n(rst_n),
        .fan_val(fan_val), .fan_lim(fan_lim),
        .zone_temp(zone_temp), .zone_lo(zone_lo), .zone_hi(zone_hi),
        .vr_hot(vr_hot), .sleep_state(sleep_state),
        .mask_fan(mask_fan), .mask_zone(mask_zone),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .host_err(host_err)
    );

    function automatic logic [9:0] raw_ev();
        logic [9:0] r;
        for (int i = 0; i < 4; i++) begin
            r[i] = fan_val[i*8 +: 8] > fan_lim[i*8 +: 8];
            r[4+i] = ($signed(zone_temp[i*8 +: 8]) < $signed(zone_lo[i*8 +: 8])) ||
                     ($signed(zone_temp[i*8 +: 8]) > $signed(zone_hi[i*8 +: 8]));
        end
        r[8] = vr_hot[0];
        r[9] = vr_hot[1];
        return r;
    endfunction

    function automatic logic [9:0] blk_ev();
        logic [9:0] b;
        for (int i = 0; i < 4; i++)
            b[i] = (sleep_state == 2'd3) || ((sleep_state == 2'd1 || sleep_state == 2'd2) && mask_fan[i]);
        b[4] = (sleep_state >= 2'd2) && mask_zone[0];
        b[5] = (sleep_state >= 2'd2) && mask_zone[1];
        b[6] = 1'b0;
        b[7] = 1'b0;
        b[8] = (sleep_state >= 2'd2);
        b[9] = (sleep_state >= 2'd2);
        return b;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock edge; model updated from the inputs held across it.
    task automatic cycle();
        logic [9:0] r, b, c;
        r = raw_ev();
        b = blk_ev();
        c = '0;
        if (reg_wr) c = (reg_addr == 1'b0) ? {6'b0, reg_wdata[3:0]} : {reg_wdata[5:0], 4'b0};
        exp_st = (r & ~b) | (exp_st & ~(c & ~r));
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic check_regs(input string tag);
        reg_addr = 1'b0;
        #1;
        check({tag, " fan"}, reg_rdata, {4'b0, exp_st[3:0]});
        reg_addr = 1'b1;
        #1;
        check({tag, " host"}, reg_rdata, {2'b0, exp_st[9:4]});
        check({tag, " R13 host_err"}, {7'b0, host_err}, {7'b0, |exp_st});
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        cycle();
    endtask

    task automatic quiet();
        fan_val   = 32'h0;
        fan_lim   = 32'hFFFF_FFFF;
        zone_temp = 32'h0;
        zone_lo   = {4{8'hF6}};
        zone_hi   = {4{8'h14}};
        vr_hot    = 2'b0;
    endtask

    task automatic clear_all();
        quiet();
        write_reg(1'b0, 8'hFF);
        write_reg(1'b1, 8'hFF);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet();
        sleep_state = 2'd0; mask_fan = 4'h0; mask_zone = 2'b0;
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = 8'h0;
        repeat (3) @(negedge clk);
        check_regs("R1 reset");
        rst_n = 1'b1;
        cycle();
        check_regs("R1 after release");

        // R2: fan 0 reading swept against limit 100
        for (int v = 0; v < 256; v++) begin
            quiet();
            fan_lim[7:0] = 8'd100;
            fan_val[7:0] = v[7:0];
            cycle();
            check_regs("R2 fan sweep");
            clear_all();
        end
        quiet();
        fan_val[31:24] = 8'h81; fan_lim[31:24] = 8'h80;
        cycle();
        check_regs("R2 fan4 position");
        clear_all();

        // R3: zone 2 temperature swept over signed range, window -10..20
        for (int t = -128; t < 128; t++) begin
            quiet();
            zone_temp[15:8] = t[7:0];
            cycle();
            check_regs("R3 zone sweep");
            clear_all();
        end

        // R4: regulator inputs
        quiet(); vr_hot = 2'b10; cycle(); check_regs("R4 vr2");
        quiet(); vr_hot = 2'b01; cycle(); check_regs("R4 vr1");
        clear_all();

        // R5: sticky after event removal
        quiet(); fan_val[23:16] = 8'hFF; fan_lim[23:16] = 8'h10; cycle();
        quiet(); cycle(); cycle();
        check_regs("R5 sticky");

        // R6: write zero keeps, write one clears
        write_reg(1'b0, 8'h00); check_regs("R6 write zero");
        write_reg(1'b1, 8'h04); check_regs("R6 wrong register");
        write_reg(1'b0, 8'h04); check_regs("R6 write one");

        // R7: refused clear while condition remains
        quiet(); zone_temp[31:24] = 8'h7F; cycle();
        write_reg(1'b1, 8'h08); check_regs("R7 refused clear");
        clear_all(); check_regs("R7 cleared after removal");

        // R8: event and clear on same edge, bit previously clear
        quiet(); vr_hot = 2'b01; write_reg(1'b1, 8'h10);
        check_regs("R8 set wins");
        clear_all();

        // R12: already set bits survive blocking
        quiet(); fan_val = 32'hFFFF_FFFF; fan_lim = 32'h0; zone_temp = {4{8'h80}}; vr_hot = 2'b11;
        cycle();
        sleep_state = 2'd3; mask_fan = 4'hF; mask_zone = 2'b11;
        quiet(); cycle();
        check_regs("R12 masks keep set bits");
        clear_all();

        // R9 R10 R11: every sleep code with every mask combination, all events active
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 64; m++) begin
                sleep_state = s[1:0];
                mask_fan    = m[3:0];
                mask_zone   = m[5:4];
                quiet();
                fan_val = 32'hFFFF_FFFF; fan_lim = 32'h0;
                zone_temp = {4{8'h80}}; vr_hot = 2'b11;
                cycle();
                check_regs("R9 R10 R11 mask sweep");
                clear_all();
            end
        end
        sleep_state = 2'd0;
        check_regs("R6 final clear");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule